// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit ports, A and B, and moves data between them either live or through one of two storage registers. One register keeps a copy of port A for delivery towards B; the other keeps a copy of port B for delivery towards A. Each register has its own capture strobe. A strobe is an ordinary signal that is sampled in the system clock domain. Every rising edge of a strobe stores the port value, whatever the enable and direction inputs are doing.

An active-low enable and a direction input choose which port, if any, the block drives. Each port has three separate vectors: an input, an output and an output enable. There are no tri-state pins. Each direction has its own select line. The select line chooses whether the driven port shows the live value from the opposite port or the stored copy. When the enable is high the block is in isolation: neither port is driven, and both registers keep capturing.

Top module: `regd_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, `a_oe` and `b_oe` are 0. Both registers are cleared to zero, and once the port is enabled that zero is seen on the outputs with the select line at 1.
- R2: A rising edge on `cap_ab` stores `a_in` into the A-to-B register. The capture takes place whatever `en_n` and `dir_b` are.
- R3: A rising edge on `cap_ba` stores `b_in` into the B-to-A register. The capture takes place whatever `en_n` and `dir_b` are.
- R4: A register keeps its value while its strobe is steady or falling. A change on the port input between rising edges does not alter the stored value.
- R5: When `en_n` is 1 (isolation), `a_oe` and `b_oe` are both 0. Captures made during isolation are kept and can be read out once the block is enabled.
- R6: When `en_n` is 0 and `dir_b` is 1, `b_oe` is 1 and `a_oe` is 0.
- R7: When `en_n` is 0 and `dir_b` is 0, `a_oe` is 1 and `b_oe` is 0.
- R8: While port B is driven, `sel_ab`=0 makes `b_out` equal to the current `a_in` in the same cycle. `sel_ab`=1 makes `b_out` equal to the A-to-B register.
- R9: While port A is driven, `sel_ba`=0 makes `a_out` equal to the current `b_in` in the same cycle. `sel_ba`=1 makes `a_out` equal to the B-to-A register.
- R10: `a_oe` and `b_oe` are never 1 together.
- R11: A port output whose enable is 0 carries all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_n | input | 1 | Output enable, active low |
| dir_b | input | 1 | 1: drive port B; 0: drive port A |
| cap_ab | input | 1 | Capture strobe for the A-to-B register |
| cap_ba | input | 1 | Capture strobe for the B-to-A register |
| sel_ab | input | 1 | Port B source: 0 live A, 1 stored A-to-B |
| sel_ba | input | 1 | Port A source: 0 live B, 1 stored B-to-A |
| a_in | input | 8 | Value present on port A |
| b_in | input | 8 | Value present on port B |
| a_out | output | 8 | Data driven onto port A |
| a_oe | output | 1 | Port A drive enable |
| b_out | output | 8 | Data driven onto port B |
| b_oe | output | 1 | Port B drive enable |

## Verification
The enables and the live or stored output data are combinational, so the bench checks them in the same cycle, half a clock after it drives an input. A strobe edge goes through two synchronizing stages and one edge-compare stage, so the register is loaded on the third clock rise after the strobe goes high. The bench therefore waits three rising edges before it reads back a stored value, and it keeps the port input steady over that window. It then lowers the strobe, changes the input, and reads again to confirm that the stored value held. Enable exclusion is also watched on every falling clock edge.

// File: rtl/regd_xcvr_pkg.sv
package regd_xcvr_pkg;
   localparam int unsigned LANES   = 2;
   localparam int unsigned LANE_AB = 0;
   localparam int unsigned LANE_BA = 1;

   typedef enum logic [1:0] {
      XM_ISOLATE = 2'b00,
      XM_DRIVE_A = 2'b01,
      XM_DRIVE_B = 2'b10
   } xcvr_mode_e;

   function automatic xcvr_mode_e decode_mode(input logic en_n, input logic dir_b);
      if (en_n)      return XM_ISOLATE;
      else if (dir_b) return XM_DRIVE_B;
      else            return XM_DRIVE_A;
   endfunction
endpackage

// File: rtl/xcvr_edge_sync.sv
module xcvr_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic rise
);
   localparam int unsigned DEPTH = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("xcvr_edge_sync: STAGES must be at least 2");
   end

   logic [DEPTH-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[DEPTH-2:0], raw};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise) else $error("edge pulse longer than one cycle"); // R4
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_store_reg: WIDTH must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (cap) q <= d;
   end

   AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (q == $past(d))) else $error("capture lost"); // R2
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(q)) else $error("register changed without capture"); // R4
endmodule

// File: rtl/xcvr_port_drive.sv
module xcvr_port_drive #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drive,
   input  logic             sel_stored,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] dout,
   output logic             oe
);
   logic [WIDTH-1:0] pick;

   always_comb begin
      pick = sel_stored ? stored : live;
      oe   = drive;
      dout = drive ? pick : '0;
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> (dout == '0)) else $error("idle port carries data"); // R11
   AST_LIVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && !sel_stored) |-> (dout == live)) else $error("live path wrong"); // R8
endmodule

// File: rtl/regd_bus_xcvr.sv
module regd_bus_xcvr
   import regd_xcvr_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_n,
   input  logic             dir_b,
   input  logic             cap_ab,
   input  logic             cap_ba,
   input  logic             sel_ab,
   input  logic             sel_ba,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);
   if (WIDTH < 1)       begin : g_bad_width  $error("regd_bus_xcvr: WIDTH must be positive"); end
   if (SYNC_STAGES < 2) begin : g_bad_stages $error("regd_bus_xcvr: SYNC_STAGES must be >= 2"); end

   xcvr_mode_e mode;
   logic [LANES-1:0]            lane_strobe, lane_rise, lane_sel, lane_drive, lane_oe;
   logic [LANES-1:0][WIDTH-1:0] lane_src, lane_q, lane_out;

   assign mode = decode_mode(en_n, dir_b);

   // lane AB: takes A, drives B ; lane BA: takes B, drives A
   assign lane_strobe[LANE_AB] = cap_ab;
   assign lane_strobe[LANE_BA] = cap_ba;
   assign lane_sel[LANE_AB]    = sel_ab;
   assign lane_sel[LANE_BA]    = sel_ba;
   assign lane_src[LANE_AB]    = a_in;
   assign lane_src[LANE_BA]    = b_in;
   assign lane_drive[LANE_AB]  = rst_n && (mode == XM_DRIVE_B);
   assign lane_drive[LANE_BA]  = rst_n && (mode == XM_DRIVE_A);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      xcvr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .raw  (lane_strobe[g]),
         .rise (lane_rise[g])
      );
      xcvr_store_reg #(.WIDTH(WIDTH)) u_reg (
         .clk  (clk),
         .rst_n(rst_n),
         .cap  (lane_rise[g]),
         .d    (lane_src[g]),
         .q    (lane_q[g])
      );
      xcvr_port_drive #(.WIDTH(WIDTH)) u_drv (
         .clk       (clk),
         .rst_n     (rst_n),
         .drive     (lane_drive[g]),
         .sel_stored(lane_sel[g]),
         .live      (lane_src[g]),
         .stored    (lane_q[g]),
         .dout      (lane_out[g]),
         .oe        (lane_oe[g])
      );
   end

   assign b_out = lane_out[LANE_AB];
   assign b_oe  = lane_oe[LANE_AB];
   assign a_out = lane_out[LANE_BA];
   assign a_oe  = lane_oe[LANE_BA];

   AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_oe && b_oe)) else $error("both ports driven"); // R10
   AST_ISOLATE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      en_n |-> (!a_oe && !b_oe)) else $error("drive during isolation"); // R5
   AST_DIR_B_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n && dir_b) |-> (b_oe && !a_oe)) else $error("B direction wrong"); // R6
   AST_DIR_A_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n && !dir_b) |-> (a_oe && !b_oe)) else $error("A direction wrong"); // R7

   always_comb begin
      if (!rst_n) begin
         AST_RESET_NO_DRIVE: assert (!a_oe && !b_oe) else $error("drive during reset"); // R1
      end
   end
endmodule

// File: tb/regd_bus_xcvr_test.sv
module regd_bus_xcvr_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_n = 1'b1, dir_b = 1'b0;
   logic       cap_ab = 1'b0, cap_ba = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
   logic [7:0] a_in = '0, b_in = '0;
   logic [7:0] a_out, b_out;
   logic       a_oe, b_oe;
   int         n_run = 0, n_fail = 0, overlap = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   regd_bus_xcvr uut (
      .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir_b(dir_b),
      .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
      .b_out(b_out), .b_oe(b_oe)
   );

   always @(negedge clk) if (a_oe && b_oe) overlap++;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // rise strobe, hold port value 3 rising edges, then drop strobe and settle
   task automatic strobe_ab(input logic [7:0] v);
      a_in = v; cap_ab = 1'b1; cyc(3);
      cap_ab = 1'b0; cyc(3);
   endtask
   task automatic strobe_ba(input logic [7:0] v);
      b_in = v; cap_ba = 1'b1; cyc(3);
      cap_ba = 1'b0; cyc(3);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; en_n = 1'b0; dir_b = 1'b1; #1;
      check(!a_oe && !b_oe, "R1 no drive in reset", {a_oe, b_oe}, 0);
      @(negedge clk); rst_n = 1'b1; sel_ab = 1'b1; a_in = 8'hFF; #1;
      check(b_out == 8'h00, "R1 AB reg zero", b_out, 0);
      dir_b = 1'b0; sel_ba = 1'b1; b_in = 8'hFF; #1;
      check(a_out == 8'h00, "R1 BA reg zero", a_out, 0);
      cyc(1);
   endtask

   task automatic t_isolation();
      en_n = 1'b1; a_in = 8'h5A; b_in = 8'hA5; #1;
      check(!a_oe && !b_oe, "R5 isolation no drive", {a_oe, b_oe}, 0);
      check(a_out == 0 && b_out == 0, "R11 idle outputs zero", {a_out, b_out}, 0);
      strobe_ab(8'h3C); strobe_ba(8'hC3);
      en_n = 1'b0; dir_b = 1'b1; sel_ab = 1'b1; a_in = 8'h00; #1;
      check(b_out == 8'h3C, "R5 R2 capture in isolation AB", b_out, 8'h3C);
      dir_b = 1'b0; sel_ba = 1'b1; b_in = 8'h00; #1;
      check(a_out == 8'hC3, "R5 R3 capture in isolation BA", a_out, 8'hC3);
      cyc(1);
   endtask

   task automatic t_live_ab();
      en_n = 1'b0; dir_b = 1'b1; sel_ab = 1'b0;
      for (int i = 0; i < 4; i++) begin
         a_in = 8'h11 * (i + 3); #1;
         check(b_out == a_in, "R8 live A to B", b_out, a_in);
         @(negedge clk);
      end
      check(b_oe && !a_oe, "R6 drive B only", {a_oe, b_oe}, 1);
      check(a_out == 0, "R11 A idle zero", a_out, 0);
   endtask

   task automatic t_live_ba();
      en_n = 1'b0; dir_b = 1'b0; sel_ba = 1'b0;
      for (int i = 0; i < 4; i++) begin
         b_in = 8'h21 + 8'h13 * i; #1;
         check(a_out == b_in, "R9 live B to A", a_out, b_in);
         @(negedge clk);
      end
      check(a_oe && !b_oe, "R7 drive A only", {a_oe, b_oe}, 2);
      check(b_out == 0, "R11 B idle zero", b_out, 0);
   endtask

   task automatic t_stored_ab();
      en_n = 1'b0; dir_b = 1'b0; sel_ab = 1'b1;
      strobe_ab(8'h96);  // captured while port A driven
      dir_b = 1'b1; a_in = 8'h01; #1;
      check(b_out == 8'h96, "R2 R8 stored A to B", b_out, 8'h96);
      a_in = 8'h77; cyc(4);
      check(b_out == 8'h96, "R4 AB hold after fall", b_out, 8'h96);
   endtask

   task automatic t_stored_ba();
      en_n = 1'b0; dir_b = 1'b1; sel_ba = 1'b1;
      strobe_ba(8'h4E);  // captured while port B driven
      dir_b = 1'b0; b_in = 8'h02; #1;
      check(a_out == 8'h4E, "R3 R9 stored B to A", a_out, 8'h4E);
      b_in = 8'hE4; cyc(4);
      check(a_out == 8'h4E, "R4 BA hold after fall", a_out, 8'h4E);
      strobe_ba(8'hB1);
      check(a_out == 8'hB1, "R3 second capture", a_out, 8'hB1);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      cyc(2);
      t_reset();
      t_isolation();
      t_live_ab();
      t_live_ba();
      t_stored_ab();
      t_stored_ba();
      check(overlap == 0, "R10 enables never both high", overlap, 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule